// File: doc/BRIEF.md
# Cascadable Reload Countdown Timer Bank

The block holds ten 8-bit down-counting frequency dividers. All ten share one base tick. That tick is a single-cycle enable taken either straight from the block clock or from every second cycle of it. Each channel starts from a reload value that software writes. When its count expires, the channel raises a pulse that lasts one clock cycle, so it divides its input tick rate by the reload value plus one.

Six of the channels (the second through the seventh) can each take their tick from the first channel's pulse instead of the base tick. This lets long periods be built from two stages. The first seven pulse lines feed a status/interrupt block that lives elsewhere. The last three act as prescaler enables for downstream peripherals.

Configuration goes through a simple synchronous write port: one address, one data byte and one write strobe. There is no read path. Everything runs in one clock domain, and every tick inside the block is a clock enable.

Top module: `cascade_divider_bank`

## Requirements
- R1: After reset, all pulse outputs are low, the bank is disabled, every count and reload value is zero, the cascade selects are clear and the half-rate tick is selected. Enabling with no reload writes therefore pulses every channel on each base tick.
- R2: A channel with reload value n (0 to 255), clocked by the full-rate tick, produces one pulse every n+1 cycles.
- R3: A channel whose count is zero loads its reload value on its next input tick instead of decrementing, and pulses in that same cycle. Otherwise a tick decrements the count by one.
- R4: A pulse is high only in a cycle that carries a base tick. In half-rate mode, a channel with reload 0 pulses on exactly half of the enabled cycles and never in two adjacent cycles.
- R5: Control bit 1 selects the base tick: 1 ticks every enabled cycle, and 0 ticks every second enabled cycle. In half-rate mode, the first tick after the enable is set falls in the second cycle after the enabling write.
- R6: Cascade select bit k, for k from 1 to 6, makes channel k+1 count pulses of channel 1 instead of base ticks.
- R7: Channels 1, 8, 9 and 10 always count the base tick. Cascade select bits 0 and 7 are ignored.
- R8: Control bit 0 is the global enable. While it is low, no channel pulses and every count holds.
- R9: Writing a reload register leaves the running count untouched. The new value is first used at that channel's next reload.
- R10: The write map is as follows. Addresses 0 to 9 hold the reload values of channels 1 to 10. Address 14 holds the cascade selects. Address 15 holds the control bits. Writes to addresses 10 to 13 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (the peripheral clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the configuration port |
| wrAddr | input | 4 | Configuration write address |
| wrData | input | 8 | Configuration write data |
| tcStatus | output | 7 | Terminal-count pulses of channels 1 to 7 (bit 0 = channel 1) |
| prescOut | output | 3 | Terminal-count pulses of channels 8 to 10 (bit 0 = channel 8) |

## Verification
Several properties are checked on every cycle, next to the counters and the tick generator:
- each counter's step rule: decrement, reload at zero, hold without a tick;
- the half-rate spacing of the base tick and the late first tick after enabling;
- the fact that a cascaded channel pulses only together with channel 1, while the fixed channels pulse only on a base tick.

Other behaviours depend on a configuration history and show up only in the bench's scenarios. These are the division ratio across the whole reload range, the deferred effect of a reload write on a running count, the ignored addresses and cascade bits, and the freeze and resume around a disable. The bench compares all ten outputs every cycle against an arithmetic model built from the requirements.

// File: rtl/divbank_pkg.sv
package divbank_pkg;
  localparam int NumCh       = 10;
  localparam int CntW        = 8;
  localparam int AddrW       = 4;
  localparam int NumStat     = 7;
  localparam int CascLo      = 1;
  localparam int CascHi      = 6;
  localparam int AddrCasc    = 14;
  localparam int AddrCtrl    = 15;
  localparam int CtrlEnBit   = 0;
  localparam int CtrlFastBit = 1;

  typedef struct packed {
    logic             baseTick;
    logic [NumCh-1:0] reloadWr;
    logic [CntW-1:0]  reloadVal;
    logic [NumCh-1:0] cascSel;
  } ctl_strobe_t;
endpackage

// File: rtl/divbank_ctrl.sv
module divbank_ctrl
  import divbank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [CntW-1:0]  wrData,
  output ctl_strobe_t      strb
);
  logic             enable;
  logic             fastSel;
  logic             halfPhase;
  logic             ctrlWr;
  logic             cascWr;
  logic [NumCh-1:0] cascReg;
  logic [NumCh-1:0] reloadHit;

  assign ctrlWr = wrEn && (wrAddr == AddrW'(AddrCtrl));
  assign cascWr = wrEn && (wrAddr == AddrW'(AddrCasc));

  // Prescaler phase runs only while enabled, so the half-rate tick
  // always starts on the second enabled cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      fastSel   <= 1'b0;
      halfPhase <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enable  <= wrData[CtrlEnBit];
        fastSel <= wrData[CtrlFastBit];
      end
      halfPhase <= enable ? ~halfPhase : 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < NumCh; i++) begin : g_ch
      assign reloadHit[i] = wrEn && (wrAddr == AddrW'(i));
      if (i >= CascLo && i <= CascHi) begin : g_casc
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)       cascReg[i] <= 1'b0;
          else if (cascWr) cascReg[i] <= wrData[i];
        end
      end else begin : g_fixed
        assign cascReg[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    strb.baseTick  = enable && (fastSel || halfPhase);
    strb.reloadWr  = reloadHit;
    strb.reloadVal = wrData;
    strb.cascSel   = cascReg;
  end

  // R8: a write clearing the enable silences the tick from the next cycle
  p_tick_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[CtrlEnBit]) |=> !strb.baseTick);

  // R5: half-rate ticks never sit in adjacent cycles
  p_half_rate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.baseTick && !fastSel && !ctrlWr) |=> !strb.baseTick);

  // R5: the first cycle after enabling carries no half-rate tick
  p_slow_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(enable) && !fastSel) |-> !strb.baseTick);
endmodule

// File: rtl/divbank_dp.sv
module divbank_dp
  import divbank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strb,
  output logic [NumCh-1:0] chPulse
);
  logic [NumCh-1:0][CntW-1:0] cnt;
  logic [NumCh-1:0][CntW-1:0] reloadReg;
  logic [NumCh-1:0]           chTick;

  generate
    for (genvar i = 0; i < NumCh; i++) begin : g_ch
      if (i >= CascLo && i <= CascHi) begin : g_src_casc
        assign chTick[i] = strb.cascSel[i] ? chPulse[0] : strb.baseTick;

        // R6: a chained channel pulses only together with channel 1
        p_chain_r6: assert property (@(posedge clk) disable iff (!rstN)
          (chPulse[i] && strb.cascSel[i]) |-> chPulse[0]);
      end else begin : g_src_base
        assign chTick[i] = strb.baseTick;

        // R7: fixed-source channels pulse only on a base tick
        p_fixed_src_r7: assert property (@(posedge clk) disable iff (!rstN)
          chPulse[i] |-> strb.baseTick);
      end

      assign chPulse[i] = chTick[i] && (cnt[i] == '0);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt[i]       <= '0;
          reloadReg[i] <= '0;
        end else begin
          if (strb.reloadWr[i]) reloadReg[i] <= strb.reloadVal;
          if (chTick[i]) cnt[i] <= (cnt[i] == '0) ? reloadReg[i] : cnt[i] - 1'b1;
        end
      end

      // R3: expiry loads the reload value held before the edge
      p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
        chPulse[i] |=> (cnt[i] == $past(reloadReg[i])));

      // R2: a tick on a nonzero count steps down by one
      p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
        (chTick[i] && cnt[i] != '0) |=> (cnt[i] == $past(cnt[i]) - 1'b1));
    end
  endgenerate

  // R8: without a base tick no counter moves
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.baseTick |=> $stable(cnt));
endmodule

// File: rtl/cascade_divider_bank.sv
module cascade_divider_bank
  import divbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [AddrW-1:0]       wrAddr,
  input  logic [CntW-1:0]        wrData,
  output logic [NumStat-1:0]     tcStatus,
  output logic [NumCh-NumStat-1:0] prescOut
);
  ctl_strobe_t      strb;
  logic [NumCh-1:0] chPulse;

  divbank_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb)
  );

  divbank_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .chPulse (chPulse)
  );

  assign tcStatus = chPulse[NumStat-1:0];
  assign prescOut = chPulse[NumCh-1:NumStat];
endmodule

// File: tb/test_cascade_divider_bank.sv
module test_cascade_divider_bank;
  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [6:0] tcStatus;
  logic [2:0] prescOut;

  cascade_divider_bank i_cascade_divider_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tcStatus(tcStatus), .prescOut(prescOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference model state
  int mCnt[10];
  int mRld[10];
  bit mEn = 0, mFast = 0, mPhase = 0;
  bit [9:0] mCasc = '0;

  int cycNo = 0, lastPulse10 = 0, gap10 = 0, cnt8 = 0;

  task automatic chk(input bit ok, input string tag, input logic [9:0] got, input logic [9:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // one cycle: drive inputs (called just after a falling edge), compare, advance model
  task automatic cycle(input bit we, input logic [3:0] a, input logic [7:0] d, input string tag);
    logic [9:0] exp, tk, got;
    bit t0, p0, oldEn;
    wrEn = we; wrAddr = a; wrData = d;
    #1;
    t0 = mEn && (mFast || mPhase);
    p0 = t0 && (mCnt[0] == 0);
    for (int i = 0; i < 10; i++) begin
      tk[i]  = (i >= 1 && i <= 6 && mCasc[i]) ? p0 : t0;
      exp[i] = tk[i] && (mCnt[i] == 0);
    end
    got = {prescOut, tcStatus};
    chk(got == exp, tag, got, exp);
    cycNo++;
    if (got[9]) begin gap10 = cycNo - lastPulse10; lastPulse10 = cycNo; end
    if (got[7]) cnt8++;
    @(posedge clk);
    for (int i = 0; i < 10; i++)
      if (tk[i]) mCnt[i] = (mCnt[i] == 0) ? mRld[i] : mCnt[i] - 1;
    oldEn = mEn;
    mPhase = oldEn ? ~mPhase : 1'b0;
    if (we) begin
      if (a < 4'd10) mRld[a] = int'(d);
      else if (a == 4'd15) begin mEn = d[0]; mFast = d[1]; end
      else if (a == 4'd14) mCasc = {2'b00, d} & 10'h07E;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cycle(0, 4'd0, 8'd0, tag);
  endtask

  initial begin
    #(ClkPeriod * 190000);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 10; i++) begin mCnt[i] = 0; mRld[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet after reset while disabled
    idle(5, "R1 reset quiet");
    // R1/R3: enable full rate with zero reloads: every channel pulses each tick
    cycle(1, 4'd15, 8'h03, "R1 enable write");
    idle(4, "R1 all pulse reload zero");
    chk({prescOut, tcStatus} == 10'h3FF, "R1 all-ones", {prescOut, tcStatus}, 10'h3FF);
    cycle(1, 4'd15, 8'h00, "R8 disable");

    // R10: program reloads, unused addresses ignored
    for (int i = 0; i < 10; i++) cycle(1, 4'(i), 8'(i + 1), "R10 reload write");
    cycle(1, 4'd7, 8'd0, "R10 reload ch8 zero");
    for (int a = 10; a < 14; a++) cycle(1, 4'(a), 8'hFF, "R10 unused addr");
    // R2/R3: full rate run
    cycle(1, 4'd15, 8'h03, "R2 enable fast");
    idle(120, "R2 full rate");
    // R5: half rate, first tick late
    cycle(1, 4'd15, 8'h00, "R8 disable");
    idle(3, "R8 held");
    cycle(1, 4'd15, 8'h01, "R5 enable slow");
    cnt8 = 0;
    idle(40, "R5 half rate");
    chk(cnt8 == 20, "R4 half-rate pulse count", 10'(cnt8), 10'd20);
    // R6/R7: cascade selects including ignored bits 0 and 7
    cycle(1, 4'd15, 8'h03, "R5 back to fast");
    cycle(1, 4'd0, 8'd2, "R6 ch1 reload");
    cycle(1, 4'd14, 8'hFF, "R7 casc all bits");
    idle(200, "R6 cascade run");
    cycle(1, 4'd14, 8'h2A, "R6 partial cascade");
    idle(150, "R6 partial run");
    // R9: rewrite a reload mid-count
    cycle(1, 4'd4, 8'd9, "R9 reload while running");
    idle(3, "R9 running");
    cycle(1, 4'd4, 8'd1, "R9 second rewrite");
    idle(60, "R9 after rewrite");
    // R8: freeze and resume
    cycle(1, 4'd15, 8'h02, "R8 disable");
    idle(30, "R8 frozen");
    cycle(1, 4'd15, 8'h03, "R8 resume");
    idle(60, "R8 resumed");
    // R2: sweep reload values on channel 10 at full rate
    cycle(1, 4'd14, 8'h00, "R2 casc off");
    begin
      int prev = 255;
      for (int n = 0; n <= 255; n += 5) begin
        cycle(1, 4'd9, 8'(n), "R2 sweep write");
        idle(prev + 1 + 2 * (n + 1) + 2, "R2 sweep");
        chk(gap10 == n + 1, "R2 divide ratio", 10'(gap10), 10'(n + 1));
        prev = n;
      end
    end
    summary();
  end
endmodule